// File: doc/BRIEF.md
# Serial Port FIFO Status Unit

This unit holds the transmit and receive word queues of a synchronous serial port and turns their fill levels into status flags, interrupt requests and DMA service requests. The processor or a DMA engine writes words into the transmit queue and reads words from the receive queue. The serial shifter reads words from the transmit queue, writes received words into the receive queue, and reports through `ser_active` whether it is currently moving data. Shifting, bit clocks and framing are handled elsewhere.

A small register interface has two addresses. Address 0 is the control word: the transmit threshold, the receive threshold, the two interrupt enables and the port enable. Address 1 clears the sticky overrun flag when a one is written to it. The status word is always visible on `status_word`. Each service flag drives two outputs at once: an interrupt request that its enable can mask, and a DMA request that no enable can mask. The overrun condition drives only an interrupt, and no bit can mask that interrupt.

Top module: `sfs_status_unit`

## Requirements
- R1: status_word bit 0 (receive not empty) is 1 exactly when the receive queue holds at least one word. It drives no interrupt.
- R2: status_word bit 1 (busy) equals `ser_active` AND the port enable (control bit 10). It is 0 while the port enable is 0.
- R3: status_word bit 2 (transmit service) is 1 when the transmit count is less than or equal to the transmit level. The level is control bits [3:0] plus one, which gives 1 to 16.
- R4: `irq_tx` equals transmit service AND the transmit interrupt enable (control bit 8). `dma_tx_req` equals transmit service whatever the enable holds.
- R5: status_word bit 3 (receive service) is 1 when the receive count is greater than or equal to the receive level. The level is control bits [7:4] plus one.
- R6: `irq_rx` equals receive service AND the receive interrupt enable (control bit 9). `dma_rx_req` equals receive service whatever the enable holds.
- R7: A serial-side word that arrives while the receive queue is full and no host pop occurs in the same cycle is discarded, and the overrun flag (status bit 4) is set. This happens again for every such word. If a host pop occurs in the same cycle, the word is accepted and no overrun is flagged.
- R8: `irq_ovr` follows the overrun flag whatever the enables hold. Overrun never drives either DMA request.
- R9: Writing address 1 with data bit 4 set clears the overrun flag. Writing that bit as 0 leaves the flag unchanged. If a clear and a new overrun fall in the same cycle, the flag ends up set.
- R10: status_word bits [12:8] give the current transmit count (0 to 16). All other status bits read 0.
- R11: After reset, both thresholds are 0, all enables are 0 and both queues are empty. As a result, transmit service and `dma_tx_req` are 1 and every other flag is 0.
- R12: Counts change at the clock edge that takes a push or a pop, so flags and requests follow one cycle later. A push and a pop on the same queue in the same cycle leave the count unchanged. This also holds on a full queue.
- R13: Both queues deliver words in the order they were written. A host push into a full transmit queue without a serial pop in the same cycle is ignored, and `tx_not_full` is 0 when the transmit count is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register address: 0 control, 1 overrun clear |
| cfg_wdata | input | 16 | Register write data |
| host_tx_push | input | 1 | Host writes a word into the transmit queue |
| host_tx_data | input | 16 | Word from the host |
| tx_not_full | output | 1 | Transmit queue has a free slot |
| host_rx_pop | input | 1 | Host takes the head of the receive queue |
| rx_rd_data | output | 16 | Head of the receive queue |
| ser_tx_pop | input | 1 | Shifter takes the head of the transmit queue |
| ser_tx_data | output | 16 | Head of the transmit queue |
| ser_tx_avail | output | 1 | Transmit queue holds a word |
| ser_rx_push | input | 1 | Shifter delivers a received word |
| ser_rx_data | input | 16 | Received word |
| ser_active | input | 1 | Shifter is transmitting or receiving |
| status_word | output | 16 | Packed status flags and transmit count |
| irq_tx | output | 1 | Maskable transmit service interrupt |
| irq_rx | output | 1 | Maskable receive service interrupt |
| irq_ovr | output | 1 | Unmaskable overrun interrupt |
| dma_tx_req | output | 1 | Transmit DMA service request |
| dma_rx_req | output | 1 | Receive DMA service request |

## Verification
Two pairs of functions can meet in one cycle. The first is a serial delivery into a full receive queue together with a host pop. The second is a new overrun together with a clear write. The bench provokes both on purpose in directed steps and again at random once the queue has filled. It judges them against a queue model in which the pop frees the slot before the push, and in which setting the overrun flag takes precedence over clearing it. Simultaneous push and pop on the transmit queue, at the empty and full bounds, is exercised the same way.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   typedef enum logic [0:0] {
      SFS_ADDR_CTRL = 1'b0,
      SFS_ADDR_OVCL = 1'b1
   } sfs_addr_e;

   localparam int SFS_ST_RNE   = 0;
   localparam int SFS_ST_BUSY  = 1;
   localparam int SFS_ST_TSV   = 2;
   localparam int SFS_ST_RSV   = 3;
   localparam int SFS_ST_OVR   = 4;
   localparam int SFS_ST_LVL   = 8;

   typedef struct packed {
      logic port_en;
      logic rx_ie;
      logic tx_ie;
   } sfs_en_t;

endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 16,
   parameter bit CLR_STORE = 1'b0,
   localparam int PTR_W    = $clog2(DEPTH),
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty,
   output logic              push_drop
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfs_fifo: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("sfs_fifo: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              push_ok, pop_ok;

   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign empty     = (cnt_q == '0);
   assign pop_ok    = pop & ~empty;
   assign push_ok   = push & (~full | pop);
   assign push_drop = push & full & ~pop;
   assign count     = cnt_q;
   assign dout      = mem[rd_ptr_q];

   if (CLR_STORE) begin : g_store_clr
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (push_ok) begin
            mem[wr_ptr_q] <= din;
         end
      end
   end else begin : g_store_plain
      always_ff @(posedge clk) begin
         if (push_ok) mem[wr_ptr_q] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
         unique case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/sfs_level_flag.sv
module sfs_level_flag #(
   parameter int THR_W       = 4,
   parameter bit AT_OR_ABOVE = 1'b0,
   localparam int CNT_W      = THR_W + 1
) (
   input  logic [CNT_W-1:0] count,
   input  logic [THR_W-1:0] thr,
   output logic             flag
);

   logic [CNT_W-1:0] level;

   assign level = CNT_W'(thr) + CNT_W'(1);

   if (AT_OR_ABOVE) begin : g_fill_side
      assign flag = (count >= level);
   end else begin : g_drain_side
      assign flag = (count <= level);
   end

endmodule

// File: rtl/sfs_ctrl_regs.sv
module sfs_ctrl_regs
   import sfs_pkg::*;
#(
   parameter int REG_W = 16,
   parameter int THR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             addr,
   input  logic [REG_W-1:0] wdata,
   input  logic             ovr_set,
   output logic [THR_W-1:0] tx_thr,
   output logic [THR_W-1:0] rx_thr,
   output sfs_en_t          en,
   output logic             ovr
);

   localparam int TIE_BIT = 2 * THR_W;
   localparam int RIE_BIT = TIE_BIT + 1;
   localparam int PEN_BIT = TIE_BIT + 2;

   if (PEN_BIT >= REG_W || SFS_ST_OVR >= REG_W) begin : g_bad_layout
      $error("sfs_ctrl_regs: control fields do not fit in REG_W");
   end

   logic ctrl_wr, ovr_clr;

   assign ctrl_wr = we & (sfs_addr_e'(addr) == SFS_ADDR_CTRL);
   assign ovr_clr = we & (sfs_addr_e'(addr) == SFS_ADDR_OVCL) & wdata[SFS_ST_OVR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_thr <= '0;
         rx_thr <= '0;
         en     <= '0;
      end else if (ctrl_wr) begin
         tx_thr     <= wdata[THR_W-1:0];
         rx_thr     <= wdata[2*THR_W-1:THR_W];
         en.tx_ie   <= wdata[TIE_BIT];
         en.rx_ie   <= wdata[RIE_BIT];
         en.port_en <= wdata[PEN_BIT];
      end
   end

   // a new overrun outranks a clear landing in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)       ovr <= 1'b0;
      else if (ovr_set) ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
   end

endmodule

// File: rtl/sfs_status_unit.sv
module sfs_status_unit
   import sfs_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 16,
   parameter int REG_W     = 16,
   parameter bit CLR_STORE = 1'b0,
   localparam int THR_W    = $clog2(DEPTH),
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              host_tx_push,
   input  logic [DATA_W-1:0] host_tx_data,
   output logic              tx_not_full,
   input  logic              host_rx_pop,
   output logic [DATA_W-1:0] rx_rd_data,
   input  logic              ser_tx_pop,
   output logic [DATA_W-1:0] ser_tx_data,
   output logic              ser_tx_avail,
   input  logic              ser_rx_push,
   input  logic [DATA_W-1:0] ser_rx_data,
   input  logic              ser_active,
   output logic [REG_W-1:0]  status_word,
   output logic              irq_tx,
   output logic              irq_rx,
   output logic              irq_ovr,
   output logic              dma_tx_req,
   output logic              dma_rx_req
);

   if (CNT_W != THR_W + 1) begin : g_bad_depth
      $error("sfs_status_unit: DEPTH must be a power of two");
   end
   if (SFS_ST_LVL + CNT_W > REG_W) begin : g_bad_status
      $error("sfs_status_unit: transmit level does not fit in status word");
   end

   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic             tx_full, tx_empty, tx_drop_unused;
   logic             rx_full_w, rx_empty;
   logic             rx_drop;
   logic [THR_W-1:0] tx_thr, rx_thr;
   sfs_en_t          en_q;
   logic             port_en_q;
   logic             ovr_q;
   logic             tx_svc, rx_svc;

   sfs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CLR_STORE(CLR_STORE)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (host_tx_push),
      .din       (host_tx_data),
      .pop       (ser_tx_pop),
      .dout      (ser_tx_data),
      .count     (tx_cnt),
      .full      (tx_full),
      .empty     (tx_empty),
      .push_drop (tx_drop_unused)
   );

   sfs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CLR_STORE(CLR_STORE)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ser_rx_push),
      .din       (ser_rx_data),
      .pop       (host_rx_pop),
      .dout      (rx_rd_data),
      .count     (rx_cnt),
      .full      (rx_full_w),
      .empty     (rx_empty),
      .push_drop (rx_drop)
   );

   sfs_ctrl_regs #(.REG_W(REG_W), .THR_W(THR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .ovr_set (rx_drop),
      .tx_thr  (tx_thr),
      .rx_thr  (rx_thr),
      .en      (en_q),
      .ovr     (ovr_q)
   );

   sfs_level_flag #(.THR_W(THR_W), .AT_OR_ABOVE(1'b0)) u_tx_flag (
      .count (tx_cnt),
      .thr   (tx_thr),
      .flag  (tx_svc)
   );

   sfs_level_flag #(.THR_W(THR_W), .AT_OR_ABOVE(1'b1)) u_rx_flag (
      .count (rx_cnt),
      .thr   (rx_thr),
      .flag  (rx_svc)
   );

   assign port_en_q    = en_q.port_en;
   assign tx_not_full  = ~tx_full;
   assign ser_tx_avail = ~tx_empty;

   assign irq_tx     = tx_svc & en_q.tx_ie;
   assign irq_rx     = rx_svc & en_q.rx_ie;
   assign dma_tx_req = tx_svc;
   assign dma_rx_req = rx_svc;
   assign irq_ovr    = ovr_q;

   always_comb begin
      status_word                        = '0;
      status_word[SFS_ST_RNE]            = ~rx_empty;
      status_word[SFS_ST_BUSY]           = ser_active & port_en_q;
      status_word[SFS_ST_TSV]            = tx_svc;
      status_word[SFS_ST_RSV]            = rx_svc;
      status_word[SFS_ST_OVR]            = ovr_q;
      status_word[SFS_ST_LVL +: CNT_W]   = tx_cnt;
   end

endmodule

// File: rtl/sfs_status_checker.sv
module sfs_status_checker #(
   parameter int REG_W = 16,
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic             cfg_addr,
   input logic [REG_W-1:0] cfg_wdata,
   input logic             host_tx_push,
   input logic             ser_tx_pop,
   input logic             host_rx_pop,
   input logic             ser_rx_push,
   input logic             rx_full_w,
   input logic             port_en_q,
   input logic [REG_W-1:0] status_word,
   input logic             irq_tx,
   input logic             irq_rx,
   input logic             irq_ovr,
   input logic             dma_tx_req,
   input logic             dma_rx_req
);

   logic             drop_now, clr_now;
   logic [CNT_W-1:0] lvl;

   assign drop_now = ser_rx_push & rx_full_w & ~host_rx_pop;
   assign clr_now  = cfg_we & cfg_addr & cfg_wdata[4];
   assign lvl      = status_word[8 +: CNT_W];

   p_rne_after_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ser_rx_push |=> status_word[0]);

   p_busy_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en_q |-> !status_word[1]);

   p_tx_dma_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |-> (dma_tx_req && status_word[2]));

   p_rx_dma_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> (dma_rx_req && status_word[3]));

   p_drop_sets_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drop_now |=> irq_ovr);

   p_full_pop_no_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_rx_push && rx_full_w && host_rx_pop && !irq_ovr) |=> !irq_ovr);

   p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_now && !drop_now) |=> !irq_ovr);

   p_w0_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ovr && !clr_now) |=> irq_ovr);

   p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lvl <= CNT_W'(DEPTH));

   p_push_pop_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (host_tx_push && ser_tx_pop && lvl != '0) |=> $stable(lvl));

endmodule

bind sfs_status_unit sfs_status_checker #(.REG_W(REG_W), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_addr     (cfg_addr),
   .cfg_wdata    (cfg_wdata),
   .host_tx_push (host_tx_push),
   .ser_tx_pop   (ser_tx_pop),
   .host_rx_pop  (host_rx_pop),
   .ser_rx_push  (ser_rx_push),
   .rx_full_w    (rx_full_w),
   .port_en_q    (port_en_q),
   .status_word  (status_word),
   .irq_tx       (irq_tx),
   .irq_rx       (irq_rx),
   .irq_ovr      (irq_ovr),
   .dma_tx_req   (dma_tx_req),
   .dma_rx_req   (dma_rx_req)
);

// File: tb/sfs_status_unit_bench.sv
module sfs_status_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DW    = 16;
   localparam int DEPTH = 16;
   localparam int RW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_addr = 1'b0;
   logic [RW-1:0] cfg_wdata = '0;
   logic          host_tx_push = 1'b0;
   logic [DW-1:0] host_tx_data = '0;
   logic          tx_not_full;
   logic          host_rx_pop = 1'b0;
   logic [DW-1:0] rx_rd_data;
   logic          ser_tx_pop = 1'b0;
   logic [DW-1:0] ser_tx_data;
   logic          ser_tx_avail;
   logic          ser_rx_push = 1'b0;
   logic [DW-1:0] ser_rx_data = '0;
   logic          ser_active = 1'b0;
   logic [RW-1:0] status_word;
   logic          irq_tx, irq_rx, irq_ovr, dma_tx_req, dma_rx_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model
   logic [DW-1:0] tx_m[$];
   logic [DW-1:0] rx_m[$];
   int   m_tthr = 0, m_rthr = 0;
   bit   m_tie = 0, m_rie = 0, m_en = 0, m_ovr = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sfs_status_unit u_sfs_status_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .host_tx_push(host_tx_push),
      .host_tx_data(host_tx_data), .tx_not_full(tx_not_full),
      .host_rx_pop(host_rx_pop), .rx_rd_data(rx_rd_data),
      .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
      .ser_tx_avail(ser_tx_avail), .ser_rx_push(ser_rx_push),
      .ser_rx_data(ser_rx_data), .ser_active(ser_active),
      .status_word(status_word), .irq_tx(irq_tx), .irq_rx(irq_rx),
      .irq_ovr(irq_ovr), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic bit exp_tsv();
      return tx_m.size() <= m_tthr + 1;
   endfunction

   function automatic bit exp_rsv();
      return rx_m.size() >= m_rthr + 1;
   endfunction

   function automatic logic [RW-1:0] exp_status();
      logic [RW-1:0] s;
      s       = '0;
      s[0]    = (rx_m.size() != 0);
      s[1]    = m_en & ser_active;
      s[2]    = exp_tsv();
      s[3]    = exp_rsv();
      s[4]    = m_ovr;
      s[12:8] = 5'(tx_m.size());
      return s;
   endfunction

   task automatic check_outputs();
      chk("R10", "status_word", 32'(status_word), 32'(exp_status()));
      chk("R4",  "irq_tx",      32'(irq_tx),      32'(exp_tsv() & m_tie));
      chk("R4",  "dma_tx_req",  32'(dma_tx_req),  32'(exp_tsv()));
      chk("R6",  "irq_rx",      32'(irq_rx),      32'(exp_rsv() & m_rie));
      chk("R6",  "dma_rx_req",  32'(dma_rx_req),  32'(exp_rsv()));
      chk("R8",  "irq_ovr",     32'(irq_ovr),     32'(m_ovr));
      chk("R13", "tx_not_full", 32'(tx_not_full), 32'(tx_m.size() < DEPTH));
      chk("R13", "ser_tx_avail",32'(ser_tx_avail),32'(tx_m.size() != 0));
   endtask

   // one clock with the currently driven inputs, model update, output check
   task automatic step();
      bit t_push, t_pop, r_push, r_pop, we, ad, drop;
      logic [RW-1:0] wd;
      logic [DW-1:0] td, rd;
      t_push = host_tx_push; t_pop = ser_tx_pop;
      r_push = ser_rx_push;  r_pop = host_rx_pop;
      we = cfg_we; ad = cfg_addr; wd = cfg_wdata;
      td = host_tx_data; rd = ser_rx_data;
      if (t_pop && tx_m.size() > 0) chk("R13", "ser_tx_data", 32'(ser_tx_data), 32'(tx_m[0]));
      if (r_pop && rx_m.size() > 0) chk("R13", "rx_rd_data", 32'(rx_rd_data), 32'(rx_m[0]));
      @(posedge clk);
      #1;
      // transmit queue: pop frees a slot before the push
      if (t_pop && tx_m.size() > 0) void'(tx_m.pop_front());
      if (t_push && tx_m.size() < DEPTH) tx_m.push_back(td);
      drop = 1'b0;
      if (r_pop && rx_m.size() > 0) void'(rx_m.pop_front());
      if (r_push) begin
         if (rx_m.size() < DEPTH) rx_m.push_back(rd);
         else drop = 1'b1;
      end
      if (drop) m_ovr = 1'b1;
      else if (we && ad && wd[4]) m_ovr = 1'b0;
      if (we && !ad) begin
         m_tthr = int'(wd[3:0]);
         m_rthr = int'(wd[7:4]);
         m_tie  = wd[8];
         m_rie  = wd[9];
         m_en   = wd[10];
      end
      host_tx_push = 1'b0; ser_tx_pop = 1'b0;
      ser_rx_push = 1'b0;  host_rx_pop = 1'b0;
      cfg_we = 1'b0;
      check_outputs();
   endtask

   task automatic write_ctrl(int tthr, int rthr, bit tie, bit rie, bit en);
      cfg_we = 1'b1; cfg_addr = 1'b0;
      cfg_wdata = RW'({5'd0, en, rie, tie, 4'(rthr), 4'(tthr)});
      step();
   endtask

   task automatic ser_deliver(logic [DW-1:0] d);
      ser_rx_push = 1'b1; ser_rx_data = d;
      step();
   endtask

   task automatic host_write(logic [DW-1:0] d);
      host_tx_push = 1'b1; host_tx_data = d;
      step();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_0017));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R11: reset state
      #1;
      chk("R11", "reset dma_tx_req", 32'(dma_tx_req), 32'd1);
      chk("R11", "reset status", 32'(status_word), 32'h0004);
      chk("R11", "reset irq_tx", 32'(irq_tx), 32'd0);
      check_outputs();

      // R3: threshold level 4, transmit flag at 4 entries, clear at 5
      write_ctrl(3, 1, 1, 1, 1);
      for (int i = 0; i < 4; i++) host_write(DW'(16'h1000 + i));
      chk("R3", "tsv at level", 32'(status_word[2]), 32'd1);
      host_write(16'h1004);
      chk("R3", "tsv above level", 32'(status_word[2]), 32'd0);

      // R12: push and pop same cycle keep count
      host_tx_push = 1'b1; host_tx_data = 16'h2222; ser_tx_pop = 1'b1;
      step();
      chk("R12", "tx level after push+pop", 32'(status_word[12:8]), 32'd5);

      // R2: busy follows ser_active and port enable
      ser_active = 1'b1; step();
      chk("R2", "busy enabled", 32'(status_word[1]), 32'd1);
      write_ctrl(3, 1, 1, 1, 0);
      chk("R2", "busy disabled", 32'(status_word[1]), 32'd0);
      ser_active = 1'b0;

      // R5/R1: receive level 2
      ser_deliver(16'hA000);
      chk("R1", "rne one entry", 32'(status_word[0]), 32'd1);
      chk("R5", "rsv below level", 32'(status_word[3]), 32'd0);
      ser_deliver(16'hA001);
      chk("R5", "rsv at level", 32'(status_word[3]), 32'd1);

      // R6: rie cleared masks irq but not dma
      write_ctrl(3, 1, 0, 0, 1);
      chk("R6", "irq_rx masked", 32'(irq_rx), 32'd0);
      chk("R6", "dma_rx unmasked", 32'(dma_rx_req), 32'd1);

      // R7: fill receive queue then overflow
      for (int i = 2; i < DEPTH; i++) ser_deliver(DW'(16'hA000 + i));
      chk("R7", "no ovr when filling", 32'(irq_ovr), 32'd0);
      ser_deliver(16'hDEAD);
      chk("R7", "ovr on drop", 32'(irq_ovr), 32'd1);
      chk("R8", "ovr irq with enables off", 32'(irq_ovr), 32'd1);
      ser_deliver(16'hBEEF);
      chk("R7", "still full after drop", 32'(rx_m.size()), 32'(DEPTH));

      // R9: write zero keeps, write one clears
      cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 16'hFFEF; step();
      chk("R9", "w0 keeps ovr", 32'(irq_ovr), 32'd1);
      cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 16'h0010; step();
      chk("R9", "w1 clears ovr", 32'(irq_ovr), 32'd0);

      // R7: delivery with host pop on full queue accepted
      ser_rx_push = 1'b1; ser_rx_data = 16'hC0DE; host_rx_pop = 1'b1; step();
      chk("R7", "push+pop on full no ovr", 32'(irq_ovr), 32'd0);

      // R9: new overrun and clear in one cycle -> set wins
      ser_rx_push = 1'b1; ser_rx_data = 16'hF00D;
      cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 16'h0010; step();
      chk("R9", "set beats clear", 32'(irq_ovr), 32'd1);

      // R5: receive level 16 only at full
      write_ctrl(0, 15, 1, 1, 1);
      chk("R5", "rsv level16 full", 32'(status_word[3]), 32'd1);
      host_rx_pop = 1'b1; step();
      chk("R5", "rsv level16 one below", 32'(status_word[3]), 32'd0);

      // R13: transmit overfill ignored, order kept
      for (int i = 0; i < 14; i++) host_write(DW'(16'h3000 + i));
      chk("R10", "tx level full", 32'(status_word[12:8]), 32'd16);
      host_write(16'h7777);
      chk("R13", "push on full ignored", 32'(status_word[12:8]), 32'd16);
      host_tx_push = 1'b1; host_tx_data = 16'h5555; ser_tx_pop = 1'b1; step();
      chk("R12", "push+pop on full tx", 32'(status_word[12:8]), 32'd16);

      // random phase
      for (int cyc = 0; cyc < 4000; cyc++) begin
         int bias;
         bias = (cyc / 500) % 4;
         host_tx_push = ($urandom % 4) < (bias + 1);
         host_tx_data = DW'($urandom);
         ser_tx_pop   = ($urandom % 4) < (4 - bias);
         ser_rx_push  = ($urandom % 4) < (bias + 1);
         ser_rx_data  = DW'($urandom);
         host_rx_pop  = ($urandom % 4) < (3 - bias);
         ser_active   = $urandom % 2;
         if ($urandom % 40 == 0) begin
            cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = RW'($urandom);
         end else if ($urandom % 12 == 0) begin
            cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = RW'($urandom);
         end
         step();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule